// File: doc/BRIEF.md
# Discrete-Input Sensor SPI Register Target

This block is the serial register front end of a 32-channel discrete-input threshold sensor. A host talks to it over a four-wire SPI link in mode 0. Each transfer opens with a command byte: its top bit picks the direction and its low seven bits name a register. Data bytes follow, most significant byte first, all inside one chip-select window. The block keeps the sensor configuration: a control byte, one sensing-mode bit per bank of eight channels, two 16-bit threshold words and a test-data byte. It drives that configuration straight to the comparator logic and serves the channel levels back as read-only status.

The channel levels arrive as a vector from comparator logic outside the block. They pass through a synchronizer. SCLK, chip select and MOSI are oversampled by the system clock, so the whole block lives in one clock domain. A read loads the addressed register's full width into a transmit shifter at the moment the command byte completes. A multi-byte status read therefore returns one coherent sample. The control register has a test mode, which swaps each status byte for the test-data byte. It also has a two-step software reset: arm the reset bit, then release it.

Top module: `spi_disc_target`

## Requirements
- R1: Bit 7 of the command byte is 1 for a read and 0 for a write. Bits 6:0 hold the register address.
- R2: Multi-byte registers move most significant byte first. A 16-bit write sends the command, then the high byte, then the low byte, and the register takes the new word only when the low byte completes.
- R3: Address 0x02 is control. Bit 0 enables test mode and drives `cfg_test_en`. Bit 1 is the reset-arm bit. Both bits read back in those positions, and the other bits read 0.
- R4: A control write with bit 1 = 0, made while bit 1 holds 1, returns every register to its reset value. The reset values are: control 0, sensing mode 0, test data 0, both thresholds 0x0206. Writing bit 1 = 1 by itself changes no other register.
- R5: Address 0x04 holds the sensing mode, driven on `cfg_bank_mode`. Bit n sets the mode of channels 8n+7..8n: 0 is ground-open sensing and 1 is supply-open sensing.
- R6: Addresses 0x10, 0x12, 0x14 and 0x16 each return one byte of channel levels: channels 7:0, 15:8, 23:16 and 31:24. Channel 8k sits in bit 0 of its byte. Address 0x78 returns all 32 levels in four bytes, with channel 31 as the first bit sent.
- R7: Address 0x3A holds the ground-open threshold word and 0x3C the supply-open word. In each, bits 15:8 hold the hysteresis and bits 7:0 the center. They drive `cfg_thr_gnd` and `cfg_thr_sup`.
- R8: Address 0x1E holds a test-data byte that can be read and written. While test mode is on, every status byte (the four bank addresses and each byte of 0x78) returns the test-data byte in place of the channel levels.
- R9: A status read returns the levels sampled when its command byte completes. Changes to `ch_level` during its data bytes do not alter the bytes sent.
- R10: Reads of unmapped addresses return 0x00, and bytes clocked out beyond a register's width are 0. Writes to read-only or unmapped addresses are ignored, and so are write bytes beyond a register's width.
- R11: Raising `spi_cs_n` aborts the transfer. A byte not finished when chip select rises commits nothing, and an SCLK rising edge seen in the same cycle as chip select rising is discarded. The next transfer starts with a command byte.
- R12: `rst` (synchronous, active high) sets all registers to the R4 reset values. `spi_miso` is 0 while chip select is high.
- R13: MOSI is sampled on SCLK rising edges and MISO changes only after SCLK falling edges. The first data bit of a read is valid before the first rising edge of the first data byte, provided each SCLK phase lasts at least 4 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCLK and chip select are oversampled by it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when deselected |
| ch_level | input | N_CH | Comparator level of each channel |
| cfg_test_en | output | 1 | Test-mode enable from control bit 0 |
| cfg_bank_mode | output | N_CH/8 | Sensing mode per bank of eight channels |
| cfg_thr_gnd | output | 16 | Ground-open threshold word (hysteresis, center) |
| cfg_thr_sup | output | 16 | Supply-open threshold word (hysteresis, center) |

## Verification
The abort path and the byte-commit path can fall in the same cycle. This happens when chip select rises at the very instant of the last SCLK rising edge of a write's data byte: both edges pass the synchronizer together and reach the shifter on the same clock. The bench provokes this by raising chip select and SCLK in the same cycle on the last bit of a test-data write. It then reads the register back and expects the old value. A second collision is a status read whose levels change while it is in flight. The bench changes `ch_level` in the middle of a wide read and expects the value sampled when the command completed.

// File: rtl/spi_disc_pkg.sv
package spi_disc_pkg;
  localparam int ADDR_W = 7;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL    = 7'h02;
  localparam addr_t A_MODE    = 7'h04;
  localparam addr_t A_BANK0   = 7'h10;
  localparam addr_t A_TEST    = 7'h1E;
  localparam addr_t A_THR_GND = 7'h3A;
  localparam addr_t A_THR_SUP = 7'h3C;
  localparam addr_t A_WIDE    = 7'h78;

  localparam logic [15:0] THR_RST = 16'h0206;

  typedef struct packed {
    logic  is_rd;
    addr_t addr;
  } cmd_t;

  function automatic logic is_writable(addr_t a);
    return (a == A_CTRL) || (a == A_MODE) || (a == A_TEST) ||
           (a == A_THR_GND) || (a == A_THR_SUP);
  endfunction
endpackage

// File: rtl/spi_disc_sync.sv
module spi_disc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_disc_shifter.sv
module spi_disc_shifter #(
  parameter int TX_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            rise,
  input  logic            fall,
  input  logic            mosi_s,
  input  logic            load,
  input  logic [TX_W-1:0] load_data,
  output logic            byte_done,
  output logic [7:0]      byte_val,
  output logic [2:0]      byte_idx,
  output logic            miso
);
  logic [2:0]      bit_cnt;
  logic [2:0]      byte_cnt;
  logic [6:0]      rx_q;
  logic [TX_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    byte_done <= 1'b0;
    if (rst || !active) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      miso     <= 1'b0;
      byte_val <= '0;
      byte_idx <= '0;
    end else begin
      if (rise) begin
        rx_q    <= {rx_q[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {rx_q, mosi_s};
          byte_idx  <= byte_cnt;
          if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
        end
      end
      if (load)
        tx_q <= load_data;
      else if (fall && byte_cnt != 3'd0)
        tx_q <= tx_q << 1;
      if (fall && byte_cnt != 3'd0)
        miso <= tx_q[TX_W-1];
    end
  end

  // R11: deselect clears the framing counters
  assert_frame_clear_R11: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_cnt == 3'd0 && byte_cnt == 3'd0 && !byte_done));

  // R12: output low while deselected
  assert_miso_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !active |=> !miso);

  // R13: output moves only on falling edges
  assert_miso_fall_only_R13: assert property (@(posedge clk) disable iff (rst)
    (active && !fall) |=> $stable(miso));
endmodule

// File: rtl/spi_disc_regs.sv
module spi_disc_regs
  import spi_disc_pkg::*;
#(
  parameter int N_CH = 32,
  localparam int N_BANK = N_CH / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [7:0]        byte_val,
  input  logic [2:0]        byte_idx,
  input  logic [N_CH-1:0]   levels,
  output logic              load,
  output logic [31:0]       load_data,
  output logic              cfg_test_en,
  output logic [N_BANK-1:0] cfg_bank_mode,
  output logic [15:0]       cfg_thr_gnd,
  output logic [15:0]       cfg_thr_sup
);
  cmd_t              cmd_q;
  logic [7:0]        hi_q;
  logic              test_q, arm_q;
  logic [N_BANK-1:0] mode_q;
  logic [7:0]        tdata_q;
  logic [15:0]       thr_gnd_q, thr_sup_q;

  logic [N_CH-1:0]   eff;
  logic [31:0]       wide_left;
  logic [31:0]       rd_word;
  logic [7:0]        mode8;
  logic              wr_b1, wr_b2, srst_fire;

  for (genvar k = 0; k < N_BANK; k++) begin : g_bank
    assign eff[8*k +: 8] = test_q ? tdata_q : levels[8*k +: 8];
  end

  assign wide_left = 32'(eff) << (32 - N_CH);

  always_comb begin
    mode8 = '0;
    mode8[N_BANK-1:0] = mode_q;
  end

  always_comb begin
    rd_word = '0;
    case (addr_t'(byte_val[6:0]))
      A_CTRL:    rd_word[31:24] = {6'b0, arm_q, test_q};
      A_MODE:    rd_word[31:24] = mode8;
      A_TEST:    rd_word[31:24] = tdata_q;
      A_THR_GND: rd_word[31:16] = thr_gnd_q;
      A_THR_SUP: rd_word[31:16] = thr_sup_q;
      A_WIDE:    rd_word        = wide_left;
      default: begin
        for (int k = 0; k < N_BANK; k++)
          if (byte_val[6:0] == 7'(A_BANK0 + 2*k))
            rd_word[31:24] = eff[8*k +: 8];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    load <= 1'b0;
    if (rst) begin
      cmd_q     <= '0;
      hi_q      <= '0;
      load_data <= '0;
    end else if (byte_done) begin
      if (byte_idx == 3'd0) begin
        cmd_q     <= cmd_t'(byte_val);
        load      <= 1'b1;
        load_data <= byte_val[7] ? rd_word : '0;
      end else if (byte_idx == 3'd1) begin
        hi_q <= byte_val;
      end
    end
  end

  assign wr_b1     = byte_done && byte_idx == 3'd1 && !cmd_q.is_rd;
  assign wr_b2     = byte_done && byte_idx == 3'd2 && !cmd_q.is_rd;
  assign srst_fire = wr_b1 && cmd_q.addr == A_CTRL && arm_q && !byte_val[1];

  always_ff @(posedge clk) begin
    if (rst || srst_fire) begin
      test_q    <= 1'b0;
      arm_q     <= 1'b0;
      mode_q    <= '0;
      tdata_q   <= '0;
      thr_gnd_q <= THR_RST;
      thr_sup_q <= THR_RST;
    end else if (wr_b1) begin
      case (cmd_q.addr)
        A_CTRL: begin test_q <= byte_val[0]; arm_q <= byte_val[1]; end
        A_MODE: mode_q  <= byte_val[N_BANK-1:0];
        A_TEST: tdata_q <= byte_val;
        default: ;
      endcase
    end else if (wr_b2) begin
      case (cmd_q.addr)
        A_THR_GND: thr_gnd_q <= {hi_q, byte_val};
        A_THR_SUP: thr_sup_q <= {hi_q, byte_val};
        default: ;
      endcase
    end
  end

  assign cfg_test_en   = test_q;
  assign cfg_bank_mode = mode_q;
  assign cfg_thr_gnd   = thr_gnd_q;
  assign cfg_thr_sup   = thr_sup_q;

  // R1: a read word is loaded only right after a command byte
  assert_load_after_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    load |-> ($past(byte_done) && $past(byte_idx) == 3'd0));

  // R4: releasing an armed reset restores every register
  assert_soft_restore_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_idx == 3'd1 && !cmd_q.is_rd && cmd_q.addr == A_CTRL &&
     arm_q && !byte_val[1])
    |=> (thr_gnd_q == THR_RST && thr_sup_q == THR_RST && mode_q == '0 &&
         tdata_q == '0 && !test_q && !arm_q));

  // R2: the 16-bit word lands as high byte then low byte
  assert_thr_order_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_idx == 3'd2 && !cmd_q.is_rd && cmd_q.addr == A_THR_SUP)
    |=> (thr_sup_q == {$past(hi_q), $past(byte_val)}));

  // R10: writes to read-only or unmapped addresses change nothing
  assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_idx != 3'd0 && !cmd_q.is_rd && !is_writable(cmd_q.addr))
    |=> $stable({test_q, arm_q, mode_q, tdata_q, thr_gnd_q, thr_sup_q}));
endmodule

// File: rtl/spi_disc_target.sv
module spi_disc_target #(
  parameter int N_CH = 32,
  parameter int SYNC_STAGES = 2,
  localparam int N_BANK = N_CH / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [N_CH-1:0]   ch_level,
  output logic              cfg_test_en,
  output logic [N_BANK-1:0] cfg_bank_mode,
  output logic [15:0]       cfg_thr_gnd,
  output logic [15:0]       cfg_thr_sup
);
  logic [2:0]      pins_s;
  logic            s_sclk, s_csn, s_mosi, p_sclk;
  logic [N_CH-1:0] lev_s;
  logic            byte_done, load;
  logic [7:0]      byte_val;
  logic [2:0]      byte_idx;
  logic [31:0]     load_data;

  spi_disc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst(rst), .d({spi_sclk, spi_cs_n, spi_mosi}), .q(pins_s));

  spi_disc_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_lev_sync (
    .clk(clk), .rst(rst), .d(ch_level), .q(lev_s));

  assign {s_sclk, s_csn, s_mosi} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) p_sclk <= 1'b0;
    else     p_sclk <= s_sclk;
  end

  spi_disc_shifter #(.TX_W(32)) u_shift (
    .clk(clk), .rst(rst), .active(!s_csn),
    .rise(s_sclk && !p_sclk), .fall(!s_sclk && p_sclk),
    .mosi_s(s_mosi), .load(load), .load_data(load_data),
    .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
    .miso(spi_miso));

  spi_disc_regs #(.N_CH(N_CH)) u_regs (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_val(byte_val),
    .byte_idx(byte_idx), .levels(lev_s), .load(load), .load_data(load_data),
    .cfg_test_en(cfg_test_en), .cfg_bank_mode(cfg_bank_mode),
    .cfg_thr_gnd(cfg_thr_gnd), .cfg_thr_sup(cfg_thr_sup));
endmodule

// File: tb/spi_disc_target_tb_top.sv
module spi_disc_target_tb_top;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [31:0] lev = 32'hA5C3_0F81;
  logic        test_en;
  logic [3:0]  bmode;
  logic [15:0] thr_g, thr_s;

  int total = 0, passed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_disc_target dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .ch_level(lev), .cfg_test_en(test_en),
    .cfg_bank_mode(bmode), .cfg_thr_gnd(thr_g), .cfg_thr_sup(thr_s));

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [2:0]  nb;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h04, 3'd1, 32'h05,       32'h0,        8'd5},
    '{1'b0, 7'h04, 3'd1, 32'h0,        32'h05,       8'd5},   // R5
    '{1'b0, 7'h04, 3'd2, 32'h0,        32'h0500,     8'd10},  // R10 byte past width
    '{1'b1, 7'h3A, 3'd2, 32'h0408,     32'h0,        8'd2},
    '{1'b0, 7'h3A, 3'd2, 32'h0,        32'h0408,     8'd2},   // R2
    '{1'b1, 7'h3C, 3'd2, 32'h0A12,     32'h0,        8'd7},
    '{1'b0, 7'h3C, 3'd2, 32'h0,        32'h0A12,     8'd7},   // R7
    '{1'b0, 7'h10, 3'd1, 32'h0,        32'h81,       8'd13},  // R13
    '{1'b0, 7'h12, 3'd1, 32'h0,        32'h0F,       8'd6},   // R6
    '{1'b0, 7'h14, 3'd1, 32'h0,        32'hC3,       8'd6},
    '{1'b0, 7'h16, 3'd1, 32'h0,        32'hA5,       8'd6},
    '{1'b0, 7'h78, 3'd4, 32'h0,        32'hA5C30F81, 8'd6},
    '{1'b1, 7'h1E, 3'd1, 32'h5A,       32'h0,        8'd1},
    '{1'b0, 7'h1E, 3'd1, 32'h0,        32'h5A,       8'd1},   // R1
    '{1'b0, 7'h20, 3'd1, 32'h0,        32'h00,       8'd10},
    '{1'b1, 7'h10, 3'd1, 32'hFF,       32'h0,        8'd10},
    '{1'b0, 7'h10, 3'd1, 32'h0,        32'h81,       8'd10},
    '{1'b1, 7'h55, 3'd1, 32'h77,       32'h0,        8'd10},
    '{1'b0, 7'h55, 3'd1, 32'h0,        32'h00,       8'd10},
    '{1'b1, 7'h02, 3'd1, 32'h01,       32'h0,        8'd3},
    '{1'b0, 7'h02, 3'd1, 32'h0,        32'h01,       8'd3},   // R3
    '{1'b0, 7'h12, 3'd1, 32'h0,        32'h5A,       8'd8},   // R8
    '{1'b0, 7'h78, 3'd4, 32'h0,        32'h5A5A5A5A, 8'd8},
    '{1'b1, 7'h02, 3'd1, 32'h00,       32'h0,        8'd3},
    '{1'b0, 7'h14, 3'd1, 32'h0,        32'hC3,       8'd8},
    '{1'b1, 7'h3A, 3'd3, 32'h0C10EE,   32'h0,        8'd10},
    '{1'b0, 7'h3A, 3'd2, 32'h0,        32'h0C10,     8'd10}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
  endtask

  task automatic xfer(input int nbits, input logic [39:0] tx, input bit abort_last,
                      input bit chg, input logic [31:0] newlev, output logic [39:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0; sclk = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[39-i];
      if (chg && i == 12) lev = newlev;
      repeat (H) @(negedge clk);
      rx[39-i] = miso;
      sclk = 1'b1;
      if (abort_last && i == nbits - 1) cs_n = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] a, input int nb, input logic [31:0] d);
    logic [39:0] rx;
    xfer(8 + 8*nb, {1'b0, a, d << (8*(4-nb))}, 1'b0, 1'b0, '0, rx);
  endtask

  task automatic do_read(input logic [6:0] a, input int nb, output logic [31:0] v);
    logic [39:0] rx;
    xfer(8 + 8*nb, {1'b1, a, 32'h0}, 1'b0, 1'b0, '0, rx);
    v = rx[31:0] >> (8*(4-nb));
  endtask

  initial begin
    logic [31:0] v;
    logic [39:0] rx;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // reset state
    check({31'b0, miso}, 32'h0, "R12 miso idle");
    check({16'b0, thr_g}, 32'h0206, "R12 gnd threshold reset");
    check({16'b0, thr_s}, 32'h0206, "R12 sup threshold reset");
    check({27'b0, test_en, bmode}, 32'h0, "R12 mode and test reset");
    do_read(7'h02, 1, v);
    check(v, 32'h0, "R12 control reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, int'(VECS[i].nb), VECS[i].data);
      else begin
        do_read(VECS[i].addr, int'(VECS[i].nb), v);
        check(v, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end
    check({28'b0, bmode}, 32'h5, "R5 bank mode output");
    check({16'b0, thr_g}, 32'h0C10, "R7 gnd threshold output");
    check({16'b0, thr_s}, 32'h0A12, "R7 sup threshold output");
    check({31'b0, test_en}, 32'h0, "R3 test enable output");

    // R9 snapshot during wide read
    lev = 32'h1122_3344;
    repeat (10) @(negedge clk);
    xfer(40, {1'b1, 7'h78, 32'h0}, 1'b0, 1'b1, 32'hFFFF_FFFF, rx);
    check(rx[31:0], 32'h1122_3344, "R9 wide read snapshot");
    do_read(7'h10, 1, v);
    check(v, 32'hFF, "R9 next read sees new levels");

    // R11 abort on the committing edge, then mid-byte
    xfer(16, {1'b0, 7'h1E, 8'h33, 24'h0}, 1'b1, 1'b0, '0, rx);
    do_read(7'h1E, 1, v);
    check(v, 32'h5A, "R11 abort on last edge");
    xfer(12, {1'b0, 7'h1E, 8'h66, 24'h0}, 1'b0, 1'b0, '0, rx);
    do_read(7'h1E, 1, v);
    check(v, 32'h5A, "R11 abort mid byte");

    // R4 soft reset
    do_write(7'h02, 1, 32'h02);
    do_read(7'h3A, 2, v);
    check(v, 32'h0C10, "R4 arm alone keeps threshold");
    do_read(7'h02, 1, v);
    check(v, 32'h02, "R4 arm bit reads back");
    do_write(7'h02, 1, 32'h00);
    do_read(7'h3A, 2, v);
    check(v, 32'h0206, "R4 gnd threshold restored");
    do_read(7'h04, 1, v);
    check(v, 32'h00, "R4 mode restored");
    do_read(7'h1E, 1, v);
    check(v, 32'h00, "R4 test data restored");
    check({16'b0, thr_s}, 32'h0206, "R4 sup threshold output restored");

    // R12 hardware reset
    do_write(7'h04, 1, 32'h0F);
    check({28'b0, bmode}, 32'hF, "R5 all banks supply-open");
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    check({28'b0, bmode}, 32'h0, "R12 hardware reset mode output");
    do_read(7'h04, 1, v);
    check(v, 32'h00, "R12 hardware reset mode read");

    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end
endmodule